// File: doc/BRIEF.md
# Four-Bit Serial-Loaded GPIO Port Register Bank

This block holds the per-pin state of a small general-purpose I/O port that sits behind a serial-bus protocol engine. The engine assembles a byte in its shift register and presents it on `shift_data`. It then pulses one of three write strobes to place the low nibble into the direction, output-value or read-polarity register. Each pin is modelled as three signals: an output enable, an output value and a sampled input level.

A read strobe captures the pin levels into an input register, and the engine shifts that register out. Before the capture, each level passes through a two-flop synchronizer and through its own per-bit polarity inversion. The pins are not sampled into that register at any other time. A 2-bit index selects which of the four registers appears on a readback nibble, which feeds the engine's shift-out path.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, direction is 4'b1111 (all inputs, so `pin_oe` is 4'b0000), output value is 4'b1111, polarity is 4'b0000 and the input register is 4'b0000.
- R2: A `wr_dir` pulse loads `shift_data[3:0]` into the direction register at that clock edge. A direction bit of 1 makes the pin an input and drives its `pin_oe` bit to 0. A direction bit of 0 makes the pin an output and drives its `pin_oe` bit to 1.
- R3: A `wr_out` pulse loads `shift_data[3:0]` into the output-value register at that edge, and `pin_do` shows that register.
- R4: A `wr_pol` pulse loads `shift_data[3:0]` into the polarity register at that edge. A polarity bit of 1 inverts that bit on the read path.
- R5: Each of the three registers changes only on its own strobe. Strobes raised in the same cycle each load their own register from the same data.
- R6: On an `rd_pulse` edge, the input register loads the synchronized pin level XOR the polarity, bit by bit. Without `rd_pulse` the input register holds its value.
- R7: A pin change applied before edge k is first captured by an `rd_pulse` at edge k+2. Captures at edges k and k+1 still return the old level.
- R8: A bit configured as an output is still read from its pin level, so the input register shows the driven value, with polarity applied.
- R9: `rb_data` selects combinationally by `rb_sel`: 0 gives the input register, 1 the output value, 2 the polarity and 3 the direction.
- R10: `shift_data[7:4]` has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| shift_data | input | 8 | Byte from the upstream shift register |
| wr_dir | input | 1 | Load strobe for the direction register |
| wr_out | input | 1 | Load strobe for the output-value register |
| wr_pol | input | 1 | Load strobe for the polarity register |
| rd_pulse | input | 1 | Capture strobe for the input register |
| rb_sel | input | 2 | Readback register index |
| pin_in | input | 4 | Pin levels as seen at the pads |
| pin_oe | output | 4 | Per-pin driver enable |
| pin_do | output | 4 | Per-pin driven value |
| in_reg | output | 4 | Captured, polarity-adjusted input register |
| rb_data | output | 4 | Selected register for shift-out |

## Verification
Register writes take effect one edge after the strobe. The bench raises each strobe on a falling edge and then checks `pin_oe`, `pin_do` or `rb_data` on the following falling edge. A pin change takes two synchronizer edges before an `rd_pulse` capture can see it, and the capture then appears one edge later. The bench therefore holds `rd_pulse` across three consecutive edges after a pin change and checks the old, old and new values one per edge. The readback mux has no register in its path, so the bench checks it a short settle delay after it changes `rb_sel`.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    RB_INPUT     = 2'd0,
    RB_OUTPUT    = 2'd1,
    RB_POLARITY  = 2'd2,
    RB_DIRECTION = 2'd3
  } rb_sel_e;
endpackage

// File: rtl/gpio_reg.sv
module gpio_reg #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (load) q <= d;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_capture.sv
module gpio_capture #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] apply_pol(input logic [W-1:0] l, input logic [W-1:0] p);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = p[i] ? ~l[i] : l[i];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (rd) q <= apply_pol(lvl, pol);
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int NBITS       = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] shift_data,
  input  logic              wr_dir,
  input  logic              wr_out,
  input  logic              wr_pol,
  input  logic              rd_pulse,
  input  logic [1:0]        rb_sel,
  input  logic [NBITS-1:0]  pin_in,
  output logic [NBITS-1:0]  pin_oe,
  output logic [NBITS-1:0]  pin_do,
  output logic [NBITS-1:0]  in_reg,
  output logic [NBITS-1:0]  rb_data
);
  import gpio_pkg::*;

  localparam logic [NBITS-1:0] DIR_RST = '1;
  localparam logic [NBITS-1:0] OUT_RST = '1;
  localparam logic [NBITS-1:0] POL_RST = '0;

  logic [NBITS-1:0] wr_nibble;
  logic [NBITS-1:0] dir_q, out_q, pol_q, sync_lvl;

  assign wr_nibble = shift_data[NBITS-1:0];

  gpio_reg #(.W(NBITS), .RST_VAL(DIR_RST)) u_dir (
    .clk(clk), .rst_n(rst_n), .load(wr_dir), .d(wr_nibble), .q(dir_q));
  gpio_reg #(.W(NBITS), .RST_VAL(OUT_RST)) u_out (
    .clk(clk), .rst_n(rst_n), .load(wr_out), .d(wr_nibble), .q(out_q));
  gpio_reg #(.W(NBITS), .RST_VAL(POL_RST)) u_pol (
    .clk(clk), .rst_n(rst_n), .load(wr_pol), .d(wr_nibble), .q(pol_q));

  gpio_sync #(.W(NBITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl));

  gpio_capture #(.W(NBITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .rd(rd_pulse), .lvl(sync_lvl), .pol(pol_q), .q(in_reg));

  // Direction bit 1 = input: both drivers off.
  assign pin_oe = ~dir_q;
  assign pin_do = out_q;

  always_comb begin
    unique case (rb_sel_e'(rb_sel))
      RB_INPUT:     rb_data = in_reg;
      RB_OUTPUT:    rb_data = out_q;
      RB_POLARITY:  rb_data = pol_q;
      RB_DIRECTION: rb_data = dir_q;
      default:      rb_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk #(
  parameter int NBITS  = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] shift_data,
  input logic              wr_dir,
  input logic              wr_out,
  input logic              wr_pol,
  input logic              rd_pulse,
  input logic [NBITS-1:0]  pin_oe,
  input logic [NBITS-1:0]  pin_do,
  input logic [NBITS-1:0]  in_reg,
  input logic [NBITS-1:0]  sync_lvl,
  input logic [NBITS-1:0]  pol_q
);
  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == ~$past(shift_data[NBITS-1:0]));

  assert_out_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> pin_do == $past(shift_data[NBITS-1:0]));

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_out |=> $stable(pin_do));

  assert_dir_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe));

  assert_pol_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pol |=> pol_q == $past(shift_data[NBITS-1:0]));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |=> in_reg == ($past(sync_lvl) ^ $past(pol_q)));

  assert_capture_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pulse |=> $stable(in_reg));
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.NBITS(NBITS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_data(shift_data), .wr_dir(wr_dir),
  .wr_out(wr_out), .wr_pol(wr_pol), .rd_pulse(rd_pulse), .pin_oe(pin_oe),
  .pin_do(pin_do), .in_reg(in_reg), .sync_lvl(sync_lvl), .pol_q(pol_q));

// File: tb/gpio_port_bank_test.sv
module gpio_port_bank_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] shift_data = '0;
  logic       wr_dir = 0, wr_out = 0, wr_pol = 0, rd_pulse = 0;
  logic [1:0] rb_sel = '0;
  logic [3:0] pin_in = '0;
  logic [3:0] pin_oe, pin_do, in_reg, rb_data;

  int checks = 0;
  int failures = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_bank uut (
    .clk(clk), .rst_n(rst_n), .shift_data(shift_data), .wr_dir(wr_dir),
    .wr_out(wr_out), .wr_pol(wr_pol), .rd_pulse(rd_pulse), .rb_sel(rb_sel),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_do(pin_do), .in_reg(in_reg),
    .rb_data(rb_data));

  task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic rb_check(input string req, input logic [1:0] sel, input logic [3:0] exp);
    rb_sel = sel;
    #1;
    check4(req, rb_data, exp);
  endtask

  // Strobe on a falling edge, result checked on the next falling edge.
  task automatic write(input logic [7:0] d, input logic s_dir, input logic s_out, input logic s_pol);
    @(negedge clk);
    shift_data = d; wr_dir = s_dir; wr_out = s_out; wr_pol = s_pol;
    @(negedge clk);
    wr_dir = 0; wr_out = 0; wr_pol = 0; shift_data = 8'h00;
  endtask

  // Pins set, held for synchronizer, then one capture.
  task automatic read_pins(input logic [3:0] pins);
    @(negedge clk);
    pin_in = pins;
    repeat (2) @(negedge clk);
    rd_pulse = 1;
    @(negedge clk);
    rd_pulse = 0;
  endtask

  task automatic t_reset;
    check4("R1 oe", pin_oe, 4'b0000);
    check4("R1 do", pin_do, 4'b1111);
    check4("R1 in", in_reg, 4'b0000);
    rb_check("R1 pol", 2'd2, 4'b0000);
    rb_check("R1 dir", 2'd3, 4'b1111);
  endtask

  task automatic t_writes;
    write(8'h05, 1, 0, 0);
    check4("R2 oe", pin_oe, 4'b1010);
    check4("R5 do unchanged", pin_do, 4'b1111);
    write(8'h06, 0, 1, 0);
    check4("R3 do", pin_do, 4'b0110);
    check4("R5 oe unchanged", pin_oe, 4'b1010);
    write(8'h09, 0, 0, 1);
    rb_check("R4 pol", 2'd2, 4'b1001);
    check4("R5 do after pol", pin_do, 4'b0110);
    write(8'hA3, 1, 1, 1);
    check4("R5 multi oe", pin_oe, 4'b1100);
    check4("R5 multi do", pin_do, 4'b0011);
    rb_check("R5 multi pol", 2'd2, 4'b0011);
    write(8'hF0, 0, 1, 0);
    check4("R10 upper nibble ignored", pin_do, 4'b0000);
    rb_check("R10 dir untouched", 2'd3, 4'b0011);
  endtask

  task automatic t_read;
    write(8'h0F, 1, 0, 0);
    write(8'h00, 0, 0, 1);
    read_pins(4'b1010);
    check4("R6 plain", in_reg, 4'b1010);
    rb_check("R9 input", 2'd0, 4'b1010);
    write(8'h03, 0, 0, 1);
    check4("R6 hold after pol write", in_reg, 4'b1010);
    read_pins(4'b1010);
    check4("R6 inverted", in_reg, 4'b1001);
    @(negedge clk); pin_in = 4'b0101;
    repeat (4) @(negedge clk);
    check4("R6 no capture without pulse", in_reg, 4'b1001);
  endtask

  task automatic t_sync;
    write(8'h00, 0, 0, 1);
    read_pins(4'b0011);
    check4("R7 baseline", in_reg, 4'b0011);
    @(negedge clk);
    pin_in = 4'b1100; rd_pulse = 1;
    @(negedge clk);
    check4("R7 edge k", in_reg, 4'b0011);
    @(negedge clk);
    check4("R7 edge k+1", in_reg, 4'b0011);
    @(negedge clk);
    check4("R7 edge k+2", in_reg, 4'b1100);
    rd_pulse = 0;
  endtask

  task automatic t_output_read;
    write(8'h00, 1, 0, 0);
    write(8'h06, 0, 1, 0);
    write(8'h01, 0, 0, 1);
    check4("R8 oe", pin_oe, 4'b1111);
    read_pins(pin_do);
    check4("R8 driven value read", in_reg, 4'b0111);
    rb_check("R9 output", 2'd1, 4'b0110);
    rb_check("R9 polarity", 2'd2, 4'b0001);
    rb_check("R9 direction", 2'd3, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_writes;
    t_read;
    t_sync;
    t_output_read;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule